// File: doc/BRIEF.md
# Abort Exception Entry Unit

This unit sits at the execute end of a three-stage fetch/decode/execute pipeline whose instructions are four bytes wide. It holds the decode and execute slots of that pipeline. Each slot carries the instruction address and a fetch-fault tag. When the fetch unit reports that an instruction could not be fetched legally, no exception is raised at that point. The tag rides along with the instruction instead. The unit raises the instruction-fetch abort only if the tagged instruction actually reaches execute. If a taken branch squashes the instruction first, the fault is dropped.

A data abort is raised when the instruction in execute is a load or store and the memory system reports an illegal access for it. Either exception empties the decode slot and discards the instruction being fetched in the same cycle, and sends fetch to a fixed vector. One cycle later the unit presents a single-cycle exception pulse, the exception kind, and the value for the abort link register. The two kinds use different link offsets. The reason is that while an instruction is in execute, the visible program counter is already two instructions past it.

The surrounding core uses `fetch_redirect` and `redirect_addr` to steer its fetch counter. It uses the registered pulse, kind and link to bank the link register and switch mode.

Top module: `abt_entry_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ex_valid`, `fetch_redirect` and `exc_taken` are 0.
- R2: An instruction presented with `if_valid` shows on `ex_valid`/`ex_addr` two cycles later unless a redirect intervenes. While it is there, `ex_pc_view` equals `ex_addr + 8`.
- R3: A fetch fault raises nothing while the tagged instruction sits in decode. It raises a redirect in the cycle that instruction occupies execute.
- R4: A tagged instruction squashed by a taken branch in execute (redirect to `ex_branch_target`) never raises an abort.
- R5: A tagged instruction in execute is treated as not executed. Its `ex_mem_op`, `ex_mem_fault` and `ex_branch_taken` inputs are ignored, and it always takes the fetch abort.
- R6: A fetch abort redirects to `VEC_BASE + 0x0C`. In the next cycle it reports `exc_kind` = 0 and `abt_link` = faulting address + 4.
- R7: A load/store in execute (`ex_mem_op`=1) with `ex_mem_fault`=1 and no tag redirects to `VEC_BASE + 0x10`. In the next cycle it reports `exc_kind` = 1 and `abt_link` = its address + 8.
- R8: When a data abort is taken while a tagged instruction sits in decode, the data abort wins and no fetch abort follows.
- R9: In the cycle after any redirect, `ex_valid` is 0, and the instruction fetched during the redirect cycle never reaches execute.
- R10: `exc_taken` is a single-cycle pulse. It is high exactly in the cycle after an exception redirect.
- R11: Link and visible-PC arithmetic wrap modulo 2^32. A data abort at 0xFFFFFFFC gives a link of 0x00000004.
- R12: `ex_mem_fault` with `ex_mem_op`=0 raises no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | Fetch delivers an instruction this cycle |
| if_addr | input | 32 | Address of the fetched instruction |
| if_fault | input | 1 | Fetch of this instruction was illegal |
| ex_mem_op | input | 1 | Instruction in execute is a load or store |
| ex_mem_fault | input | 1 | Memory system rejects the executing access |
| ex_branch_taken | input | 1 | Instruction in execute is a taken branch |
| ex_branch_target | input | 32 | Target of that branch |
| ex_valid | output | 1 | Execute slot holds an instruction |
| ex_addr | output | 32 | Address of the instruction in execute |
| ex_pc_view | output | 32 | Program counter as seen by the executing instruction |
| fetch_redirect | output | 1 | Flush decode/fetch and load a new fetch address |
| redirect_addr | output | 32 | New fetch address |
| exc_taken | output | 1 | One-cycle abort entry pulse |
| exc_kind | output | 1 | 0 = fetch abort, 1 = data abort |
| abt_link | output | 32 | Value for the abort link register |

## Verification
The bench builds the unit with its default parameters: two pipeline slots, four-byte instructions, a vector base of 0 and 32-bit addresses. With these values the +4/+8 link offsets, the 0x0C/0x10 vectors and the wrap at the top of the address space are concrete numbers that can be checked. The 32-bit width lets a branch to 0xFFFFFFFC push the link past the top of the address space, which covers the wrap case. Instruction sequences place a fault tag behind a taken branch, behind a faulting load, and on an instruction whose execute-side inputs are all asserted. This shows where the deferred tag can be discarded and where it must fire.

// File: rtl/abt_pkg.sv
package abt_pkg;
    parameter int unsigned XLEN = 32;

    typedef enum logic {
        ABT_FETCH = 1'b0,
        ABT_DATA  = 1'b1
    } abt_kind_e;

    typedef struct packed {
        logic            valid;
        logic            tag;
        logic [XLEN-1:0] addr;
    } slot_t;

    typedef struct packed {
        logic            taken;
        abt_kind_e       kind;
        logic [XLEN-1:0] link;
    } exc_out_t;
endpackage

// File: rtl/abt_pipe_slot.sv
module abt_pipe_slot
    import abt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  kill,
    input  slot_t in_slot,
    output slot_t out_slot
);
    slot_t slot_d, slot_q;

    always_comb begin
        slot_d       = in_slot;
        slot_d.tag   = in_slot.tag & in_slot.valid;
        if (kill) begin
            slot_d.valid = 1'b0;
            slot_d.tag   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign out_slot = slot_q;
endmodule

// File: rtl/abt_arbiter.sv
module abt_arbiter
    import abt_pkg::*;
#(
    parameter logic [XLEN-1:0] IABT_ADV = 4,
    parameter logic [XLEN-1:0] DABT_ADV = 8,
    parameter logic [XLEN-1:0] IABT_VEC = 32'h0000_000C,
    parameter logic [XLEN-1:0] DABT_VEC = 32'h0000_0010
) (
    input  slot_t           ex_slot,
    input  logic            mem_op,
    input  logic            mem_fault,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_target,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_addr,
    output logic            take,
    output abt_kind_e       kind,
    output logic [XLEN-1:0] link
);
    logic fetch_abt, data_abt, branch_go;

    always_comb begin
        fetch_abt = ex_slot.valid & ex_slot.tag;
        data_abt  = ex_slot.valid & ~ex_slot.tag & mem_op & mem_fault;
        branch_go = ex_slot.valid & ~ex_slot.tag & ~data_abt & br_taken;

        take     = fetch_abt | data_abt;
        redirect = take | branch_go;
        kind     = data_abt ? ABT_DATA : ABT_FETCH;

        if (data_abt) begin
            redirect_addr = DABT_VEC;
            link          = ex_slot.addr + DABT_ADV;
        end else if (fetch_abt) begin
            redirect_addr = IABT_VEC;
            link          = ex_slot.addr + IABT_ADV;
        end else begin
            redirect_addr = br_target;
            link          = ex_slot.addr + IABT_ADV;
        end
    end
endmodule

// File: rtl/abt_entry_unit.sv
module abt_entry_unit
    import abt_pkg::*;
#(
    parameter int unsigned     INSN_BYTES   = 4,
    parameter int unsigned     PIPE_SLOTS   = 2,
    parameter logic [XLEN-1:0] VEC_BASE     = '0,
    parameter logic [XLEN-1:0] IABT_VEC_OFF = 32'h0000_000C,
    parameter logic [XLEN-1:0] DABT_VEC_OFF = 32'h0000_0010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            if_valid,
    input  logic [XLEN-1:0] if_addr,
    input  logic            if_fault,
    input  logic            ex_mem_op,
    input  logic            ex_mem_fault,
    input  logic            ex_branch_taken,
    input  logic [XLEN-1:0] ex_branch_target,
    output logic            ex_valid,
    output logic [XLEN-1:0] ex_addr,
    output logic [XLEN-1:0] ex_pc_view,
    output logic            fetch_redirect,
    output logic [XLEN-1:0] redirect_addr,
    output logic            exc_taken,
    output logic            exc_kind,
    output logic [XLEN-1:0] abt_link
);
    localparam logic [XLEN-1:0] PC_AHEAD = XLEN'(PIPE_SLOTS * INSN_BYTES);
    localparam logic [XLEN-1:0] IABT_ADV = XLEN'((PIPE_SLOTS - 1) * INSN_BYTES);
    localparam logic [XLEN-1:0] IABT_VEC = VEC_BASE + IABT_VEC_OFF;
    localparam logic [XLEN-1:0] DABT_VEC = VEC_BASE + DABT_VEC_OFF;

    slot_t     chain [PIPE_SLOTS+1];
    slot_t     ex_slot;
    logic      take;
    abt_kind_e kind;
    logic [XLEN-1:0] link;
    exc_out_t  out_d, out_q;

    assign chain[0] = '{valid: if_valid, tag: if_fault, addr: if_addr};

    for (genvar k = 0; k < PIPE_SLOTS; k++) begin : g_slot
        abt_pipe_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .kill    (fetch_redirect),
            .in_slot (chain[k]),
            .out_slot(chain[k+1])
        );
    end

    assign ex_slot = chain[PIPE_SLOTS];

    abt_arbiter #(
        .IABT_ADV(IABT_ADV),
        .DABT_ADV(PC_AHEAD),
        .IABT_VEC(IABT_VEC),
        .DABT_VEC(DABT_VEC)
    ) u_arb (
        .ex_slot      (ex_slot),
        .mem_op       (ex_mem_op),
        .mem_fault    (ex_mem_fault),
        .br_taken     (ex_branch_taken),
        .br_target    (ex_branch_target),
        .redirect     (fetch_redirect),
        .redirect_addr(redirect_addr),
        .take         (take),
        .kind         (kind),
        .link         (link)
    );

    always_comb begin
        out_d       = out_q;
        out_d.taken = take;
        if (take) begin
            out_d.kind = kind;
            out_d.link = link;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign ex_valid   = ex_slot.valid;
    assign ex_addr    = ex_slot.addr;
    assign ex_pc_view = ex_slot.addr + PC_AHEAD;
    assign exc_taken  = out_q.taken;
    assign exc_kind   = out_q.kind;
    assign abt_link   = out_q.link;

    // R9
    flush_empties_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_redirect |=> !ex_valid);

    // R10
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> !exc_taken);

    // R10
    taken_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> $past(fetch_redirect));

    // R3
    tag_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_slot.tag) |-> (fetch_redirect && redirect_addr == IABT_VEC));

    // R6
    iabt_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && !exc_kind) |-> (abt_link == $past(ex_addr) + IABT_ADV));

    // R7
    dabt_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && exc_kind) |-> (abt_link == $past(ex_addr) + PC_AHEAD));
endmodule

// File: tb/sim_abt_entry_unit.sv
`timescale 1ns/1ps
module sim_abt_entry_unit;
    typedef struct packed {
        logic        v;
        logic        t;
        logic [31:0] a;
    } ent_t;

    logic clk = 0, rst_n = 0;
    logic if_valid = 0, if_fault = 0, ex_mem_op = 0, ex_mem_fault = 0, ex_branch_taken = 0;
    logic [31:0] if_addr = 0, ex_branch_target = 0;
    logic ex_valid, fetch_redirect, exc_taken, exc_kind;
    logic [31:0] ex_addr, ex_pc_view, redirect_addr, abt_link;

    int checks = 0, failures = 0;
    bit done = 0;

    ent_t pipe[$];
    logic [31:0] fpc;
    logic m_taken, m_kind;
    logic [31:0] m_link;
    logic s_redir, s_taken, s_kind, s_exv;
    logic [31:0] s_raddr, s_link, s_exa, s_pcv;

    always #5 clk = ~clk;

    abt_entry_unit u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit flt, input bit mop, input bit mf, input bit br, input logic [31:0] bt);
        ent_t e;
        bit iab, dab, brr, red;
        logic [31:0] ra;
        @(negedge clk);
        if_valid = 1; if_addr = fpc; if_fault = flt;
        ex_mem_op = mop; ex_mem_fault = mf; ex_branch_taken = br; ex_branch_target = bt;
        #1;
        e   = pipe[0];
        iab = e.v && e.t;
        dab = e.v && !e.t && mop && mf;
        brr = e.v && !e.t && !dab && br;
        red = iab || dab || brr;
        ra  = dab ? 32'h10 : (iab ? 32'h0C : bt);
        s_redir = fetch_redirect; s_raddr = redirect_addr; s_taken = exc_taken;
        s_kind = exc_kind; s_link = abt_link; s_exv = ex_valid; s_exa = ex_addr; s_pcv = ex_pc_view;
        chk(ex_valid == e.v, "R2 ex_valid", {31'b0, ex_valid}, {31'b0, e.v});
        if (e.v) begin
            chk(ex_addr == e.a, "R2 ex_addr", ex_addr, e.a);
            chk(ex_pc_view == e.a + 32'd8, "R2 ex_pc_view", ex_pc_view, e.a + 32'd8);
        end
        chk(fetch_redirect == red, "R9 fetch_redirect", {31'b0, fetch_redirect}, {31'b0, red});
        if (red) chk(redirect_addr == ra, "R9 redirect_addr", redirect_addr, ra);
        chk(exc_taken == m_taken, "R10 exc_taken", {31'b0, exc_taken}, {31'b0, m_taken});
        if (m_taken) begin
            chk(exc_kind == m_kind, "R10 exc_kind", {31'b0, exc_kind}, {31'b0, m_kind});
            chk(abt_link == m_link, "R10 abt_link", abt_link, m_link);
        end
        @(posedge clk);
        m_taken = iab || dab;
        if (iab || dab) begin
            m_kind = dab;
            m_link = e.a + (dab ? 32'd8 : 32'd4);
        end
        void'(pipe.pop_front());
        pipe.push_back('{v: 1'b1, t: flt, a: fpc});
        if (red) begin
            pipe.delete();
            pipe.push_back('0);
            pipe.push_back('0);
        end
        fpc = red ? ra : fpc + 32'd4;
    endtask

    task automatic plain();
        cyc(0, 0, 0, 0, 32'h0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        pipe.push_back('0);
        pipe.push_back('0);
        m_taken = 0; m_kind = 0; m_link = 0;
        fpc = 32'h0000_0100;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!ex_valid && !fetch_redirect && !exc_taken, "R1 reset",
            {29'b0, ex_valid, fetch_redirect, exc_taken}, 32'h0);
        rst_n = 1;

        // R2 straight-line stream
        plain(); plain(); plain();
        chk(s_exv && s_exa == 32'h100, "R2 first arrival", s_exa, 32'h100);
        chk(s_pcv == 32'h108, "R2 pc view", s_pcv, 32'h108);
        plain();

        // R3 / R6 deferred fetch abort
        a = fpc;
        cyc(1, 0, 0, 0, 0);
        plain();
        chk(!s_redir, "R3 tagged in decode quiet", {31'b0, s_redir}, 32'h0);
        plain();
        chk(s_redir && s_raddr == 32'h0C, "R6 fetch abort vector", s_raddr, 32'h0C);
        plain();
        chk(s_taken && !s_kind, "R6 fetch abort kind", {30'b0, s_taken, s_kind}, 32'h2);
        chk(s_link == a + 32'd4, "R6 fetch abort link", s_link, a + 32'd4);
        chk(!s_exv, "R9 ex empty after flush", {31'b0, s_exv}, 32'h0);
        plain(); plain();

        // R4 tagged instruction behind a taken branch
        plain();
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 32'h200);
        chk(s_redir && s_raddr == 32'h200, "R4 branch redirect", s_raddr, 32'h200);
        for (int i = 0; i < 4; i++) begin
            plain();
            chk(!s_taken && !(s_redir && s_raddr == 32'h0C), "R4 squashed tag silent",
                {31'b0, s_taken}, 32'h0);
        end

        // R5 tagged instruction ignores execute-side inputs
        a = fpc;
        cyc(1, 0, 0, 0, 0);
        plain();
        cyc(0, 1, 1, 1, 32'h300);
        chk(s_redir && s_raddr == 32'h0C, "R5 tag wins over ex inputs", s_raddr, 32'h0C);
        plain();
        chk(s_taken && !s_kind && s_link == a + 32'd4, "R5 fetch abort link", s_link, a + 32'd4);
        plain(); plain();

        // R7 data abort
        a = fpc;
        plain(); plain();
        cyc(0, 1, 1, 0, 0);
        chk(s_redir && s_raddr == 32'h10, "R7 data abort vector", s_raddr, 32'h10);
        plain();
        chk(s_taken && s_kind, "R7 data abort kind", {30'b0, s_taken, s_kind}, 32'h3);
        chk(s_link == a + 32'd8, "R7 data abort link", s_link, a + 32'd8);
        plain(); plain();

        // R8 data abort beats younger tag
        a = fpc;
        plain();
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 1, 0, 0);
        chk(s_raddr == 32'h10, "R8 data vector", s_raddr, 32'h10);
        plain();
        chk(s_taken && s_kind && s_link == a + 32'd8, "R8 data abort taken", s_link, a + 32'd8);
        for (int i = 0; i < 3; i++) begin
            plain();
            chk(!s_taken && !s_redir, "R8 younger tag flushed", {30'b0, s_taken, s_redir}, 32'h0);
        end

        // R11 wrap at the top of the address space
        plain(); plain();
        cyc(0, 0, 0, 1, 32'hFFFF_FFFC);
        plain(); plain();
        cyc(0, 1, 1, 0, 0);
        chk(s_exa == 32'hFFFF_FFFC && s_pcv == 32'h4, "R11 pc view wraps", s_pcv, 32'h4);
        plain();
        chk(s_taken && s_kind && s_link == 32'h4, "R11 link wraps", s_link, 32'h4);
        plain(); plain();

        // R12 fault without memory op
        plain(); plain();
        cyc(0, 0, 1, 0, 0);
        chk(!s_redir, "R12 no redirect", {31'b0, s_redir}, 32'h0);
        plain();
        chk(!s_taken, "R12 no exception", {31'b0, s_taken}, 32'h0);
        plain(); plain();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule